// File: doc/BRIEF.md
# Interrupt Latency History Buffer

This block keeps a rolling log of serviced interrupts so that the time each one spent waiting can be inspected afterwards. Whenever a source becomes pending, the block notes the current cycle count against that source's id. When the interrupt is accepted, a log entry is made. The entry holds the id, the cycle stored at raise time and the current cycle. Entries go into a circular buffer of `DEPTH` slots. Once every slot is full, the oldest entry is overwritten.

A separate read port walks the log from the newest entry to older ones. For each entry it returns the latency, which is the taken cycle minus the raised cycle. It also returns the spacing between this entry and the next newer one. A slot that has never been written reads as invalid, and this is where a walk ends. A free-running counter tallies every interrupt accepted and every direct software raise.

Top module: `irq_hist`

## Requirements
- R1: When `raise_i` is high at a clock edge, the per-id stamp for `raise_id_i` takes the value of `cycle_i`. Every stamp is 0 after reset.
- R2: When `take_i` is high at a clock edge, the slot at the write pointer receives the id `take_id_i`, the taken cycle `cycle_i` and that id's stamp as it stood before the edge. A raise of the same id in the same cycle does not affect the logged raised cycle.
- R3: The write pointer advances by one on every take and wraps from `DEPTH-1` to 0. Once more than `DEPTH` takes have occurred, only the newest `DEPTH` entries can be read.
- R4: Read index k selects slot (write_pointer − k − 1) mod `DEPTH`. k = 0 is the newest entry and k = 1 the one before it.
- R5: A slot whose taken cycle is 0 reads as `rd_valid_o` = 0, and every data output of the read port is then 0. Reset clears all slots, the write pointer, the stamps and the counter.
- R6: For a valid entry, `rd_latency_o` = taken cycle − raised cycle, modulo 2^32.
- R7: For a valid entry with k ≥ 1, `rd_delta_vld_o` = 1 and `rd_delta_o` = taken cycle of entry k−1 − taken cycle of entry k. For k = 0, `rd_delta_vld_o` = 0 and `rd_delta_o` = 0.
- R8: `raised_cnt_o` goes up by one for each take and by one for each `sw_raise_i`. It goes up by two when both occur in the same cycle. `raise_i` alone does not change it. The counter wraps at 2^`CNT_W`.
- R9: The read port is registered. Outputs for the index present at a clock edge appear after that edge, and they stay unchanged between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_i | input | 32 | Current cycle count |
| raise_i | input | 1 | A source has become pending |
| raise_id_i | input | 5 | Id of the pending source |
| take_i | input | 1 | An interrupt is accepted |
| take_id_i | input | 5 | Id of the accepted interrupt |
| sw_raise_i | input | 1 | Direct software raise request |
| rd_idx_i | input | log2(DEPTH) | Read index, 0 = newest |
| rd_valid_o | output | 1 | Selected slot holds an entry |
| rd_id_o | output | 5 | Logged id |
| rd_raised_o | output | 32 | Logged raised cycle |
| rd_taken_o | output | 32 | Logged taken cycle |
| rd_latency_o | output | 32 | Taken minus raised |
| rd_delta_vld_o | output | 1 | A newer entry exists for the delta |
| rd_delta_o | output | 32 | Spacing to the next newer entry |
| raised_cnt_o | output | CNT_W | Interrupts raised counter |

## Verification
The assertions assume that `raise_id_i` and `take_id_i` are valid ids whenever their strobes are high. They also assume that `cycle_i` is never 0 on a take, because a taken cycle of 0 would be read back as an empty slot. The stimulus starts its cycle count at 1 after every reset and only increases it, so no logged entry can look empty. The stimulus also keeps every id below 32. The ring is overfilled only once, and this is enough to show that the pointer wraps and the oldest entries are displaced.

// File: rtl/irq_hist_pkg.sv
package irq_hist_pkg;
  localparam int unsigned CYC_W   = 32;
  localparam int unsigned ID_W    = 5;
  localparam int unsigned NUM_IDS = 1 << ID_W;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [CYC_W-1:0] raised;
    logic [CYC_W-1:0] taken;
  } hist_ent_t;
endpackage

// File: rtl/irq_stamp_tbl.sv
module irq_stamp_tbl
  import irq_hist_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [ID_W-1:0]  set_id_i,
  input  logic [CYC_W-1:0] cycle_i,
  input  logic [ID_W-1:0]  rd_id_i,
  output logic [CYC_W-1:0] rd_stamp_o
);
  logic [CYC_W-1:0] stamp_q [NUM_IDS];

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_stamp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              stamp_q[g] <= '0;
      else if (set_i && set_id_i == ID_W'(g))   stamp_q[g] <= cycle_i;
    end
  end

  // read sees the value before this edge's update
  assign rd_stamp_o = stamp_q[rd_id_i];

  a_r1_stamp_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> stamp_q[$past(set_id_i)] == $past(cycle_i));
endmodule

// File: rtl/irq_ring.sv
module irq_ring
  import irq_hist_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
)(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  hist_ent_t        wr_ent_i,
  output logic [IDX_W-1:0] ptr_o,
  input  logic [IDX_W-1:0] rd_a_addr_i,
  output hist_ent_t        rd_a_o,
  input  logic [IDX_W-1:0] rd_b_addr_i,
  output logic [CYC_W-1:0] rd_b_taken_o
);
  hist_ent_t        mem_q [DEPTH];
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (wr_i) ptr_q <= ptr_q + 1'b1;  // DEPTH is a power of two
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[g] <= '0;
      else if (wr_i && ptr_q == IDX_W'(g))   mem_q[g] <= wr_ent_i;
    end
  end

  assign ptr_o        = ptr_q;
  assign rd_a_o       = mem_q[rd_a_addr_i];
  assign rd_b_taken_o = mem_q[rd_b_addr_i].taken;

  a_r3_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ptr_q == IDX_W'($past(ptr_q) + 1'b1));
  a_r3_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ptr_q));
  a_r2_slot_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mem_q[$past(ptr_q)] == $past(wr_ent_i));
endmodule

// File: rtl/irq_readout.sv
module irq_readout
  import irq_hist_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
)(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ptr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [IDX_W-1:0] addr_a_o,
  output logic [IDX_W-1:0] addr_b_o,
  input  hist_ent_t        ent_a_i,
  input  logic [CYC_W-1:0] ent_b_taken_i,
  output logic             valid_o,
  output logic [ID_W-1:0]  id_o,
  output logic [CYC_W-1:0] raised_o,
  output logic [CYC_W-1:0] taken_o,
  output logic [CYC_W-1:0] latency_o,
  output logic             delta_vld_o,
  output logic [CYC_W-1:0] delta_o
);
  logic a_vld, d_vld;

  assign addr_a_o = ptr_i - rd_idx_i - 1'b1;
  assign addr_b_o = addr_a_o + 1'b1;          // next newer slot
  assign a_vld    = ent_a_i.taken != '0;
  assign d_vld    = a_vld && rd_idx_i != '0 && ent_b_taken_i != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      id_o        <= '0;
      raised_o    <= '0;
      taken_o     <= '0;
      latency_o   <= '0;
      delta_vld_o <= 1'b0;
      delta_o     <= '0;
    end else begin
      valid_o     <= a_vld;
      id_o        <= a_vld ? ent_a_i.id : '0;
      raised_o    <= a_vld ? ent_a_i.raised : '0;
      taken_o     <= ent_a_i.taken;
      latency_o   <= a_vld ? ent_a_i.taken - ent_a_i.raised : '0;
      delta_vld_o <= d_vld;
      delta_o     <= d_vld ? ent_b_taken_i - ent_a_i.taken : '0;
    end
  end

  a_r7_newest_no_delta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_i == '0 |=> !delta_vld_o && delta_o == '0);
  a_r5_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> id_o == '0 && latency_o == '0 && !delta_vld_o);
  a_r9_hold_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_idx_i) && $stable(ptr_i) && $stable(ent_a_i) && $stable(ent_b_taken_i))
      |=> $stable(taken_o));
endmodule

// File: rtl/irq_hist.sv
module irq_hist
  import irq_hist_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
)(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CYC_W-1:0] cycle_i,
  input  logic             raise_i,
  input  logic [ID_W-1:0]  raise_id_i,
  input  logic             take_i,
  input  logic [ID_W-1:0]  take_id_i,
  input  logic             sw_raise_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [ID_W-1:0]  rd_id_o,
  output logic [CYC_W-1:0] rd_raised_o,
  output logic [CYC_W-1:0] rd_taken_o,
  output logic [CYC_W-1:0] rd_latency_o,
  output logic             rd_delta_vld_o,
  output logic [CYC_W-1:0] rd_delta_o,
  output logic [CNT_W-1:0] raised_cnt_o
);
  logic [CYC_W-1:0] stamp;
  hist_ent_t        wr_ent, ent_a;
  logic [IDX_W-1:0] ptr, addr_a, addr_b;
  logic [CYC_W-1:0] ent_b_taken;
  logic [CNT_W-1:0] cnt_q;

  irq_stamp_tbl u_stamp (
    .clk_i, .rst_ni,
    .set_i(raise_i), .set_id_i(raise_id_i), .cycle_i,
    .rd_id_i(take_id_i), .rd_stamp_o(stamp)
  );

  assign wr_ent = '{id: take_id_i, raised: stamp, taken: cycle_i};

  irq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i, .rst_ni,
    .wr_i(take_i), .wr_ent_i(wr_ent), .ptr_o(ptr),
    .rd_a_addr_i(addr_a), .rd_a_o(ent_a),
    .rd_b_addr_i(addr_b), .rd_b_taken_o(ent_b_taken)
  );

  irq_readout #(.DEPTH(DEPTH)) u_rd (
    .clk_i, .rst_ni,
    .ptr_i(ptr), .rd_idx_i,
    .addr_a_o(addr_a), .addr_b_o(addr_b),
    .ent_a_i(ent_a), .ent_b_taken_i(ent_b_taken),
    .valid_o(rd_valid_o), .id_o(rd_id_o), .raised_o(rd_raised_o),
    .taken_o(rd_taken_o), .latency_o(rd_latency_o),
    .delta_vld_o(rd_delta_vld_o), .delta_o(rd_delta_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(take_i) + CNT_W'(sw_raise_i);
  end
  assign raised_cnt_o = cnt_q;

  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> raised_cnt_o == CNT_W'($past(raised_cnt_o) + $past(take_i) + $past(sw_raise_i)));
  a_r8_raise_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raise_i && !take_i && !sw_raise_i) |=> $stable(raised_cnt_o));
endmodule

// File: tb/sim_irq_hist.sv
`timescale 1ns/1ps
module sim_irq_hist;
  localparam int DEPTH = 16;
  localparam int IDX_W = 4;
  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cycle_i = '0;
  logic        raise_i = 1'b0, take_i = 1'b0, sw_raise_i = 1'b0;
  logic [4:0]  raise_id_i = '0, take_id_i = '0;
  logic [IDX_W-1:0] rd_idx_i = '0;
  logic        rd_valid_o, rd_delta_vld_o;
  logic [4:0]  rd_id_o;
  logic [31:0] rd_raised_o, rd_taken_o, rd_latency_o, rd_delta_o;
  logic [CNT_W-1:0] raised_cnt_o;

  always #4 clk = ~clk;

  irq_hist #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni, .cycle_i, .raise_i, .raise_id_i, .take_i, .take_id_i,
    .sw_raise_i, .rd_idx_i, .rd_valid_o, .rd_id_o, .rd_raised_o, .rd_taken_o,
    .rd_latency_o, .rd_delta_vld_o, .rd_delta_o, .raised_cnt_o
  );

  int checks = 0, errors = 0;
  logic [31:0] now;
  logic [31:0] m_stamp [32];
  logic [31:0] h_raise [512], h_take [512];
  int          h_id [512];
  int          n;
  int          m_cnt;

  // {raise, raise_id, take, take_id, sw}
  localparam logic [12:0] VEC [12] = '{
    13'b1_00010_0_00000_0, 13'b1_00101_0_00000_0, 13'b0_00000_1_00010_0,
    13'b0_00000_0_00000_0, 13'b1_00111_1_00101_0, 13'b0_00000_0_00000_1,
    13'b0_00000_1_00111_1, 13'b1_00010_0_00000_0, 13'b0_00000_0_00000_0,
    13'b0_00000_1_00010_0, 13'b1_00001_1_00001_0, 13'b0_00000_0_00000_1
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_stamp[i] = '0;
    n = 0; m_cnt = 0; now = 32'd1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    raise_i = 0; take_i = 0; sw_raise_i = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic step(input bit r, input int rid, input bit t, input int tid, input bit sw);
    @(negedge clk);
    raise_i = r; raise_id_i = 5'(rid); take_i = t; take_id_i = 5'(tid);
    sw_raise_i = sw; cycle_i = now;
    @(posedge clk);
    if (t) begin
      h_id[n] = tid; h_raise[n] = m_stamp[tid]; h_take[n] = now; n++;
    end
    if (r) m_stamp[rid] = now;
    m_cnt = m_cnt + (t ? 1 : 0) + (sw ? 1 : 0);
    now++;
    #2;
    raise_i = 0; take_i = 0; sw_raise_i = 0;
  endtask

  task automatic check_read(input int k);
    int  e, lim;
    bit  v;
    @(negedge clk);
    rd_idx_i = IDX_W'(k);
    @(posedge clk);
    #2;
    lim = (n < DEPTH) ? n : DEPTH;
    v = k < lim;
    e = n - 1 - k;
    check(rd_valid_o == v, "R5 valid", 64'(rd_valid_o), 64'(v));
    if (v) begin
      check(rd_id_o == 5'(h_id[e]), "R4 id", 64'(rd_id_o), 64'(h_id[e]));
      check(rd_taken_o == h_take[e], "R2 taken", 64'(rd_taken_o), 64'(h_take[e]));
      check(rd_raised_o == h_raise[e], "R2 raised", 64'(rd_raised_o), 64'(h_raise[e]));
      check(rd_latency_o == h_take[e] - h_raise[e], "R6 latency",
            64'(rd_latency_o), 64'(h_take[e] - h_raise[e]));
      check(rd_delta_vld_o == (k > 0), "R7 delta_vld", 64'(rd_delta_vld_o), 64'(k > 0));
      if (k > 0)
        check(rd_delta_o == h_take[e+1] - h_take[e], "R7 delta",
              64'(rd_delta_o), 64'(h_take[e+1] - h_take[e]));
      else
        check(rd_delta_o == 0, "R7 newest delta", 64'(rd_delta_o), 0);
    end else begin
      check(rd_id_o == 0 && rd_latency_o == 0 && !rd_delta_vld_o, "R5 empty zero",
            {rd_id_o, rd_latency_o}, 0);
    end
  endtask

  task automatic check_cnt(input string req);
    check(raised_cnt_o == CNT_W'(m_cnt), req, 64'(raised_cnt_o), 64'(m_cnt));
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    model_reset();
    do_reset();
    // reset state
    check_cnt("R5 reset count");
    check_read(0);

    // vector walk: counter after every step (R8), then full readback (R4)
    foreach (VEC[i]) begin
      step(VEC[i][12], int'(VEC[i][11:7]), VEC[i][6], int'(VEC[i][5:1]), VEC[i][0]);
      check_cnt("R8 count");
    end
    for (int k = 0; k < DEPTH; k++) check_read(k);

    // R1/R2: raise and take of same id in one cycle logs the older stamp
    step(1, 9, 0, 0, 0);
    hold = now - 1;
    step(0, 0, 0, 0, 0);
    step(1, 9, 1, 9, 0);
    check_read(0);
    check(rd_raised_o == hold, "R2 same-cycle raise", 64'(rd_raised_o), 64'(hold));
    // R1: the new stamp is used by the next take of id 9
    step(0, 0, 1, 9, 0);
    check_read(0);
    check(rd_raised_o == now - 2, "R1 stamp update", 64'(rd_raised_o), 64'(now - 2));

    // R9: output holds until the next edge after an index change
    @(negedge clk);
    rd_idx_i = 1;
    #1;
    check(rd_taken_o == h_take[n-1], "R9 registered hold", 64'(rd_taken_o), 64'(h_take[n-1]));
    @(posedge clk);
    #2;
    check(rd_taken_o == h_take[n-2], "R9 after edge", 64'(rd_taken_o), 64'(h_take[n-2]));

    // R3: overfill the ring and read it all back
    for (int i = 0; i < DEPTH + 5; i++) step(i % 3 == 0, i % 32, 1, (i + 4) % 32, 0);
    for (int k = 0; k < DEPTH; k++) check_read(k);
    check_cnt("R8 count after wrap");

    // R5: reset mid-run clears slots, stamps and counter
    do_reset();
    check_cnt("R5 count cleared");
    check_read(0);
    step(0, 0, 1, 4, 0);
    check_read(0);
    check(rd_raised_o == 0, "R5 stamp cleared", 64'(rd_raised_o), 0);
    check_read(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule